// File: doc/BRIEF.md
# Repeat-Count Control-Word Sequencer

This block sits between a slow external control port and a datapath that runs on a clock several times faster. The source supplies "sections". A section is a control word plus a repeat count that says how long the word must be held. The block buffers sections in a short stack of stages and plays them out on the fast clock. Each word reaches the datapath for exactly its repeat count plus one cycles. A run of sections sent back to back therefore reaches the datapath as one unbroken stream.

The source hands over sections through an asynchronous strobe/busy handshake. The busy line is low while the block can take a section. The source then places the word and count on the inputs and raises the strobe. The block synchronizes the strobe into the fast domain and raises busy. It takes the section into its top stage as soon as that stage can move, then drops busy again.

While no section is offered, empty stages are filled with internal no-operation entries (word zero). A stage that holds such an entry is overwritten on the next cycle by the stage above it, so external sections drop toward the output without gaps. The source fills the stages ahead of an uninterruptible run by sending a leading all-zero section with a long count. Hold time is measured by a one-hot shift timer, and expiry is read from its lowest bit alone.

Top module: `cwfifo_seq`

## Requirements
- R1: While reset is high and after it is released, busy_o is 0 and dp_word_o is 0. All stages hold internal no-operation entries, so the output idles at word 0.
- R2: A rising edge on strobe_i, driven between clock edges while busy_o is low, makes busy_o read 0 after two rising clock edges and 1 after the third.
- R3: While busy_o is high and the top stage can move, the top stage takes ext_word_i and ext_rpt_i as an external entry, and busy_o returns to 0 on that same edge. When the stages have room, busy_o is therefore high for exactly one cycle.
- R4: While busy_o is low, ext_word_i and ext_rpt_i have no effect. The top stage takes an internal entry with word 0, count 0 and the external flag clear, and dp_word_o stays 0.
- R5: An external section with count field c appears on dp_word_o for exactly c+1 consecutive cycles.
- R6: The count field is RPT_W bits wide (4 by default). The largest value, 2^RPT_W-1, holds its word for 2^RPT_W cycles. The hold timer is one-hot at all times.
- R7: Stages holding internal entries are removed on the next cycle by moving every stage above them down one place. External sections keep their order, and once the stages are prefilled no word-0 cycle appears between consecutive sections.
- R8: When every stage holds an external entry and the timer has not expired, the top stage does not load and busy_o stays high.
- R9: When the bottom stage holds an internal entry at expiry, dp_word_o is 0 for one cycle. After the last section, dp_word_o returns to 0.
- R10: A synchronous reset applied in the middle of a run restores the state of R1 and discards all buffered sections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Asynchronous strobe; a rising edge offers a section |
| ext_word_i | input | CW_W | Offered control word |
| ext_rpt_i | input | RPT_W | Offered repeat count (held count+1 cycles) |
| busy_o | output | 1 | High from strobe detection until the section is taken |
| dp_word_o | output | CW_W | Control word driven to the datapath |

## Verification
Some rules are checked on every cycle, and the stream scenarios cover the rest.

Checked on every cycle:
- The output word changes only after a timer expiry.
- The hold timer stays one-hot.
- busy rises only after a detected strobe edge and falls only when an external entry lands in the top stage.
- A load while busy is low yields an internal entry.
- A full stack of external entries holds busy high.

Shown only by the scenarios:
- Each section is expanded to its exact length.
- Sections arrive in order with no word-0 cycle between them.
- The source stalls when the stages back up.
- A reset in the middle of a run clears everything.

// File: rtl/cwseq_pkg.sv
package cwseq_pkg;

    parameter int unsigned CW_W  = 8;
    parameter int unsigned RPT_W = 4;
    localparam int unsigned TLEN = 1 << RPT_W;

    typedef struct packed {
        logic             ext;
        logic [RPT_W-1:0] rpt;
        logic [CW_W-1:0]  word;
    } sect_t;

    function automatic logic [TLEN-1:0] rpt_onehot(input logic [RPT_W-1:0] r);
        logic [TLEN-1:0] v;
        v    = '0;
        v[r] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cwseq_strobe_sync.sv
module cwseq_strobe_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);

    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], async_i};
    end

    assign rise_o = sh_q[1] & ~sh_q[2];

endmodule

// File: rtl/cwseq_rpt_timer.sv
module cwseq_rpt_timer
    import cwseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RPT_W-1:0] rpt_i,
    output logic             expire_o,
    output logic [TLEN-1:0]  timer_o
);

    logic [TLEN-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (rst)             timer_q <= TLEN'(1);
        else if (timer_q[0]) timer_q <= rpt_onehot(rpt_i);
        else                 timer_q <= timer_q >> 1;
    end

    assign expire_o = timer_q[0];
    assign timer_o  = timer_q;

endmodule

// File: rtl/cwseq_stage_chain.sv
module cwseq_stage_chain
    import cwseq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv_i,
    input  sect_t in_sect_i,
    output sect_t bottom_o,
    output logic  top_take_o,
    output logic  top_ext_o,
    output logic  all_ext_o
);

    sect_t            stg_q [DEPTH];
    logic [DEPTH-1:0] hole;
    logic [DEPTH-1:0] take;

    // cascaded OR: a stage moves if any stage at or below it is internal
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            acc     = acc | ~stg_q[i].ext;
            hole[i] = acc;
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(DEPTH); g++) begin : g_stage
            sect_t nxt;
            assign take[g] = adv_i | hole[g];
            if (g == int'(DEPTH) - 1) begin : g_top
                assign nxt = in_sect_i;
            end else begin : g_mid
                assign nxt = stg_q[g+1];
            end
            always_ff @(posedge clk) begin
                if (rst)          stg_q[g] <= '0;
                else if (take[g]) stg_q[g] <= nxt;
            end
        end
    endgenerate

    assign bottom_o   = stg_q[0];
    assign top_take_o = take[DEPTH-1];
    assign top_ext_o  = stg_q[DEPTH-1].ext;
    assign all_ext_o  = ~hole[DEPTH-1];

endmodule

// File: rtl/cwfifo_seq.sv
module cwfifo_seq
    import cwseq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_i,
    input  logic [CW_W-1:0]  ext_word_i,
    input  logic [RPT_W-1:0] ext_rpt_i,
    output logic             busy_o,
    output logic [CW_W-1:0]  dp_word_o
);

    logic            strb_rise;
    logic            expire;
    logic [TLEN-1:0] tmr_vec;
    logic            top_take;
    logic            top_ext;
    logic            all_ext;
    logic            busy_q;
    logic [CW_W-1:0] dp_q;
    sect_t           in_sect;
    sect_t           bottom;

    cwseq_strobe_sync i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (strobe_i),
        .rise_o  (strb_rise)
    );

    // inputs gated with busy: no offer means an internal zero entry
    always_comb begin
        in_sect = '0;
        if (busy_q) begin
            in_sect.ext  = 1'b1;
            in_sect.rpt  = ext_rpt_i;
            in_sect.word = ext_word_i;
        end
    end

    cwseq_stage_chain #(.DEPTH(DEPTH)) i_chain (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (expire),
        .in_sect_i  (in_sect),
        .bottom_o   (bottom),
        .top_take_o (top_take),
        .top_ext_o  (top_ext),
        .all_ext_o  (all_ext)
    );

    cwseq_rpt_timer i_tmr (
        .clk      (clk),
        .rst      (rst),
        .rpt_i    (bottom.rpt),
        .expire_o (expire),
        .timer_o  (tmr_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)                     busy_q <= 1'b0;
        else if (busy_q && top_take) busy_q <= 1'b0;
        else if (!busy_q && strb_rise) busy_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         dp_q <= '0;
        else if (expire) dp_q <= bottom.word;
    end

    assign busy_o    = busy_q;
    assign dp_word_o = dp_q;

endmodule

// File: rtl/cwfifo_seq_chk.sv
module cwfifo_seq_chk
    import cwseq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic [CW_W-1:0] dp_word,
    input logic            expire,
    input logic            rise,
    input logic            top_take,
    input logic            top_ext,
    input logic            all_ext,
    input logic [TLEN-1:0] timer
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && dp_word == '0));

    a_r2_busy_after_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rise));

    a_r3_busy_fall_loads: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> top_ext);

    a_r4_idle_load_internal: assert property (@(posedge clk) disable iff (rst)
        (!busy && top_take) |=> !top_ext);

    a_r5_word_held: assert property (@(posedge clk) disable iff (rst)
        !$past(expire) |-> $stable(dp_word));

    a_r6_timer_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(timer) == 1);

    a_r8_full_stall: assert property (@(posedge clk) disable iff (rst)
        (busy && all_ext && !expire) |=> busy);

endmodule

bind cwfifo_seq cwfifo_seq_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy_o),
    .dp_word  (dp_word_o),
    .expire   (expire),
    .rise     (strb_rise),
    .top_take (top_take),
    .top_ext  (top_ext),
    .all_ext  (all_ext),
    .timer    (tmr_vec)
);

// File: tb/test_cwfifo_seq.sv
module test_cwfifo_seq;
    import cwseq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             strobe = 1'b0;
    logic [CW_W-1:0]  ext_word = '0;
    logic [RPT_W-1:0] ext_rpt = '0;
    logic             busy;
    logic [CW_W-1:0]  dp_word;

    int n_vec = 0;
    int n_bad = 0;
    int max_busy = 0;
    int phase = 0;
    bit mon_on = 1'b0;
    logic [CW_W-1:0] expq[$];

    always #10 clk = ~clk;

    cwfifo_seq #(.DEPTH(4)) i_cwfifo_seq (
        .clk        (clk),
        .rst        (rst),
        .strobe_i   (strobe),
        .ext_word_i (ext_word),
        .ext_rpt_i  (ext_rpt),
        .busy_o     (busy),
        .dp_word_o  (dp_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_sect(input logic [CW_W-1:0] w, input logic [RPT_W-1:0] r);
        for (int k = 0; k <= int'(r); k++) expq.push_back(w);
    endtask

    task automatic send(input logic [CW_W-1:0] w, input logic [RPT_W-1:0] r, input bit probe);
        int hi;
        @(negedge clk);
        while (busy) @(negedge clk);
        ext_word = w;
        ext_rpt  = r;
        strobe   = 1'b1;
        if (probe) begin
            @(negedge clk);
            @(negedge clk);
            chk(busy == 1'b0, "R2", busy, 0);
            @(negedge clk);
            chk(busy == 1'b1, "R2", busy, 1);
            @(negedge clk);
            chk(busy == 1'b0, "R3", busy, 0);
        end else begin
            do @(negedge clk); while (!busy);
        end
        strobe = 1'b0;
        hi = 1;
        while (busy) begin
            @(negedge clk);
            hi++;
        end
        if (hi > max_busy) max_busy = hi;
        repeat (2) @(negedge clk);
    endtask

    // reference stream: zeros until the first section, then the exact expansion, then zeros
    always @(negedge clk) begin
        if (mon_on) begin
            logic [CW_W-1:0] e;
            if (phase == 0 && dp_word != '0) phase = 1;
            if (phase == 0) begin
                chk(dp_word == '0, "R4", dp_word, 0);
            end else if (expq.size() > 0) begin
                e = expq.pop_front();
                chk(dp_word == e, "R5 R6 R7", dp_word, e);
            end else begin
                chk(dp_word == '0, "R9", dp_word, 0);
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", busy, 0);
        chk(dp_word == '0, "R1", dp_word, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && dp_word == '0, "R1", {busy, dp_word}, 0);

        // R4: data on the inputs without a strobe is ignored
        ext_word = 8'hFF;
        ext_rpt  = 4'd7;
        mon_on   = 1'b1;
        repeat (20) @(negedge clk);

        // scenario 1: prefilled atomic run with short and long sections
        expect_sect(8'h11, 4'd0);
        expect_sect(8'h22, 4'd1);
        expect_sect(8'h33, 4'd15);
        expect_sect(8'h44, 4'd2);
        expect_sect(8'h55, 4'd13);
        expect_sect(8'h66, 4'd0);
        expect_sect(8'h77, 4'd15);
        expect_sect(8'h88, 4'd4);
        expect_sect(8'h99, 4'd15);
        expect_sect(8'hAA, 4'd0);
        send(8'h00, 4'd15, 1'b1);
        send(8'h00, 4'd15, 1'b0);
        send(8'h11, 4'd0, 1'b0);
        send(8'h22, 4'd1, 1'b0);
        send(8'h33, 4'd15, 1'b0);
        send(8'h44, 4'd2, 1'b0);
        send(8'h55, 4'd13, 1'b0);
        send(8'h66, 4'd0, 1'b0);
        send(8'h77, 4'd15, 1'b0);
        send(8'h88, 4'd4, 1'b0);
        send(8'h99, 4'd15, 1'b0);
        send(8'hAA, 4'd0, 1'b0);
        while (expq.size() > 0) @(negedge clk);
        repeat (20) @(negedge clk);

        // scenario 2: source faster than drain, stages back up (R8)
        mon_on   = 1'b0;
        phase    = 0;
        max_busy = 0;
        for (int k = 1; k <= 12; k++) expect_sect(CW_W'(8'h10 + k), 4'd15);
        mon_on = 1'b1;
        for (int k = 1; k <= 12; k++) send(CW_W'(8'h10 + k), 4'd15, 1'b0);
        chk(max_busy > 2, "R8", max_busy, 3);
        while (expq.size() > 0) @(negedge clk);
        repeat (10) @(negedge clk);
        mon_on = 1'b0;

        // scenario 3: reset in the middle of a run
        send(8'h3C, 4'd15, 1'b0);
        send(8'h4D, 4'd15, 1'b0);
        while (dp_word != 8'h3C) @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(dp_word == '0, "R10", dp_word, 0);
        chk(busy == 1'b0, "R10", busy, 0);
        rst = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(dp_word == '0, "R10", dp_word, 0);
        end

        summary();
        $finish;
    end

endmodule